// File: doc/BRIEF.md
# Accumulator ALU with Registered Condition Flags

This block is the arithmetic and logic unit of a small accumulator machine. One operand is always the accumulator and the other comes from the shared data bus. A 3-bit function code and a single carry-in bit choose the operation. The result is produced combinationally in the same cycle the inputs are presented, so the datapath around the ALU can load it into a register on the next clock edge.

Two condition indications are derived from the result: Zero, set when every bit of the result is zero, and Negative, the sign bit of the result. Both are captured in flip-flops on every clock edge. A branch decided in the cycle after an ALU operation therefore sees the state of that operation, even though by then the ALU is doing something else, such as passing the accumulator through during an instruction fetch. Function code zero is the idle default and passes the accumulator, so the flags keep tracking the accumulator in cycles that request no operation. Arithmetic is two's complement modulo 2^WIDTH. Subtraction and negation wrap with no carry or overflow output.

Top module: `status_alu`

## Requirements
- R1: Function code 0 (3'b000) drives the result with the accumulator operand unchanged.
- R2: Function code 1 (3'b001) drives the result with the bus operand unchanged.
- R3: Function code 2 (3'b010) drives the result with the bitwise complement of the accumulator.
- R4: Function code 3 (3'b011) drives the result with the bitwise AND of bus operand and accumulator.
- R5: Function code 4 (3'b100) drives the result with the bitwise OR of bus operand and accumulator.
- R6: Function code 5 (3'b101) drives the result with accumulator + bus operand + carry-in, modulo 2^WIDTH.
- R7: Function code 6 (3'b110) drives the result with the two's complement negation of the bus operand, modulo 2^WIDTH (negating zero gives zero).
- R8: Function code 7 (3'b111) drives the result with accumulator minus bus operand, modulo 2^WIDTH, wrapping silently.
- R9: The carry-in has no effect on the result for any function code other than 5.
- R10: The registered zero flag output equals 1 exactly when the result present before the latest rising clock edge was all zeros.
- R11: The registered negative flag output equals bit WIDTH-1 of the result present before the latest rising clock edge.
- R12: While the active-low reset is asserted both flag outputs are 0, whatever the result, and asserting reset clears them without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags are captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag registers |
| acc_i | input | WIDTH | Accumulator operand |
| bus_i | input | WIDTH | Second operand taken from the shared bus |
| func_i | input | 3 | Operation select, encoding as in R1 to R8 |
| cin_i | input | 1 | Carry-in, used only by the add function |
| result_o | output | WIDTH | Combinational result |
| zero_q_o | output | 1 | Registered zero flag of the previous cycle's result |
| neg_q_o | output | 1 | Registered sign flag of the previous cycle's result |

## Verification
The bench builds the block with WIDTH = 12 and the shared adder variant, the default values. At twelve bits the sign bit 11 and the 4096 wrap point are reachable with directed operands such as 0x7FF + 1, 0 - 1 and the negation of 0x800, while random operands spread over the whole range exercise every function with the carry-in toggled. Flags are checked one clock after each operation against the result the bench predicted, including across an asynchronous reset in the middle of the run.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;

  typedef enum logic [2:0] {
    OP_PASS_ACC = 3'b000,
    OP_PASS_BUS = 3'b001,
    OP_NOT_ACC  = 3'b010,
    OP_AND      = 3'b011,
    OP_OR       = 3'b100,
    OP_ADD      = 3'b101,
    OP_NEG_BUS  = 3'b110,
    OP_SUB      = 3'b111
  } alu_op_e;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import status_alu_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter bit SHARE_ADDER = 1'b1
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic [2:0]       func_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] result_o
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  alu_op_e           op;
  logic [WIDTH-1:0]  arith;
  logic [WIDTH-1:0]  logic_res;

  assign op = alu_op_e'(func_i);

  // Bitwise and pass-through functions
  always_comb begin
    unique case (op)
      OP_PASS_ACC: logic_res = acc_i;
      OP_PASS_BUS: logic_res = bus_i;
      OP_NOT_ACC:  logic_res = ~acc_i;
      OP_AND:      logic_res = bus_i & acc_i;
      OP_OR:       logic_res = bus_i | acc_i;
      default:     logic_res = acc_i;
    endcase
  end

  generate
    if (SHARE_ADDER) begin : g_shared
      // One adder serves add, subtract and negate
      logic [WIDTH-1:0] opa;
      logic [WIDTH-1:0] opb;
      logic             cy;
      always_comb begin
        unique case (op)
          OP_SUB: begin
            opa = acc_i;
            opb = ~bus_i;
            cy  = 1'b1;
          end
          OP_NEG_BUS: begin
            opa = ZERO;
            opb = ~bus_i;
            cy  = 1'b1;
          end
          default: begin
            opa = acc_i;
            opb = bus_i;
            cy  = cin_i;
          end
        endcase
      end
      assign arith = opa + opb + {{(WIDTH-1){1'b0}}, cy};
    end else begin : g_separate
      // Independent units, shallower select after each
      logic [WIDTH-1:0] sum;
      logic [WIDTH-1:0] diff;
      logic [WIDTH-1:0] neg;
      assign sum  = acc_i + bus_i + {{(WIDTH-1){1'b0}}, cin_i};
      assign diff = acc_i - bus_i;
      assign neg  = ZERO - bus_i;
      always_comb begin
        unique case (op)
          OP_SUB:     arith = diff;
          OP_NEG_BUS: arith = neg;
          default:    arith = sum;
        endcase
      end
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_NEG_BUS: result_o = arith;
      default:                    result_o = logic_res;
    endcase
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_q_o,
  output logic             neg_q_o
);

  localparam int SIGN_BIT = WIDTH - 1;

  logic zero_now;
  assign zero_now = (res_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q_o <= 1'b0;
      neg_q_o  <= 1'b0;
    end else begin
      zero_q_o <= zero_now;
      neg_q_o  <= res_i[SIGN_BIT];
    end
  end

  // Checker state: one cycle has been captured since reset
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_zero_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (zero_q_o == ($past(res_i) == '0)));

  assert_neg_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (neg_q_o == $past(res_i[SIGN_BIT])));

  assert_both_flags_R10_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !(zero_q_o && neg_q_o));

endmodule

// File: rtl/status_alu.sv
module status_alu
  import status_alu_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter bit SHARE_ADDER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic [2:0]       func_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_q_o,
  output logic             neg_q_o
);

  logic [WIDTH-1:0] res;

  alu_datapath #(
    .WIDTH       (WIDTH),
    .SHARE_ADDER (SHARE_ADDER)
  ) u_datapath (
    .acc_i    (acc_i),
    .bus_i    (bus_i),
    .func_i   (func_i),
    .cin_i    (cin_i),
    .result_o (res)
  );

  alu_flag_reg #(
    .WIDTH (WIDTH)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_i    (res),
    .zero_q_o (zero_q_o),
    .neg_q_o  (neg_q_o)
  );

  assign result_o = res;

  assert_pass_acc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (func_i == OP_PASS_ACC) |-> (result_o == acc_i));

  assert_pass_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (func_i == OP_PASS_BUS) |-> (result_o == bus_i));

  assert_not_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (func_i == OP_NOT_ACC) |-> ((result_o ^ acc_i) == {WIDTH{1'b1}}));

  assert_neg_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (func_i == OP_NEG_BUS) |-> (WIDTH'(result_o + bus_i) == '0));

  assert_sub_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (func_i == OP_SUB) |-> (WIDTH'(result_o + bus_i) == acc_i));

endmodule

// File: tb/status_alu_tb.sv
`timescale 1ns/1ps
module status_alu_tb;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] acc = '0;
  logic [W-1:0] bus = '0;
  logic [2:0]   func = 3'd0;
  logic         cin = 1'b0;
  logic [W-1:0] result;
  logic         zq;
  logic         nq;

  int total = 0;
  int bad = 0;
  bit have_prev = 0;
  bit exp_z = 0;
  bit exp_n = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  status_alu #(.WIDTH(W), .SHARE_ADDER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .bus_i(bus),
    .func_i(func), .cin_i(cin), .result_o(result),
    .zero_q_o(zq), .neg_q_o(nq)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2:0] f, input logic c);
    case (f)
      3'd0: return a;
      3'd1: return b;
      3'd2: return ~a;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return W'(a + b + W'(c));
      3'd6: return W'(0 - b);
      default: return W'(a - b);
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_flags();
    if (have_prev) begin
      chk("R10", W'(zq), W'(exp_z));
      chk("R11", W'(nq), W'(exp_n));
    end
  endtask

  // Drive one operation at the falling edge, check result, then predict flags
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [2:0] f, input logic c);
    logic [W-1:0] e;
    @(negedge clk);
    check_flags();
    acc = a; bus = b; func = f; cin = c;
    #1;
    e = model(a, b, f, c);
    chk(req_of(f), result, e);
    if (f != 3'd5) begin
      // R9: flipping carry-in leaves the result unchanged
      cin = ~c;
      #0.5;
      chk("R9", result, e);
      cin = c;
      #0.5;
    end
    exp_z = (e == '0);
    exp_n = e[W-1];
    have_prev = 1;
  endtask

  initial begin
    // R12: flags stay low in reset even with a zero result
    acc = '0; func = 3'd0;
    repeat (3) @(negedge clk);
    chk("R12", W'(zq), '0);
    chk("R12", W'(nq), '0);
    acc = 12'h800;
    @(negedge clk);
    chk("R12", W'(nq), '0);
    rst_n = 1'b1;

    // Directed corners
    step(12'h000, 12'h000, 3'd0, 1'b1);   // R1 zero pass
    step(12'h9A5, 12'h123, 3'd0, 1'b0);   // R1 negative pass
    step(12'h000, 12'hFFF, 3'd1, 1'b1);   // R2
    step(12'hFFF, 12'h000, 3'd2, 1'b0);   // R3 gives zero
    step(12'hF0F, 12'h0F0, 3'd3, 1'b0);   // R4 zero
    step(12'hF00, 12'h00F, 3'd4, 1'b1);   // R5
    step(12'h7FF, 12'h000, 3'd5, 1'b1);   // R6 crosses sign
    step(12'hFFF, 12'h000, 3'd5, 1'b1);   // R6 wraps to zero
    step(12'h7FF, 12'h001, 3'd5, 1'b0);   // R6
    step(12'h123, 12'h000, 3'd6, 1'b1);   // R7 negate zero
    step(12'h000, 12'h800, 3'd6, 1'b0);   // R7 most negative
    step(12'h000, 12'h001, 3'd6, 1'b0);   // R7 gives FFF
    step(12'h000, 12'h001, 3'd7, 1'b1);   // R8 wrap below zero
    step(12'h555, 12'h555, 3'd7, 1'b0);   // R8 zero
    step(12'h800, 12'h001, 3'd7, 1'b0);   // R8 wrap to positive

    // Random operations with a fixed seed
    void'($urandom(32'd7341));
    for (int i = 0; i < 400; i++) begin
      step(W'($urandom), W'($urandom), 3'($urandom), 1'($urandom));
    end

    // R12: asynchronous reset mid-run clears a set negative flag
    step(12'h800, 12'h000, 3'd0, 1'b0);
    @(negedge clk);
    check_flags();
    chk("R11", W'(nq), 12'd1);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R12", W'(zq), '0);
    chk("R12", W'(nq), '0);
    have_prev = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step(12'h000, 12'h000, 3'd0, 1'b0);
    step(12'h001, 12'h000, 3'd0, 1'b0);
    @(negedge clk);
    check_flags();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule